// File: doc/BRIEF.md
# Weighted-Bit ADC Output Correction Unit

This block sits behind a multi-channel converter whose every sample is made of two partial results: a 3-bit coarse code from a multiplying-DAC front stage and a 12-bit fine code from a successive-approximation stage. The two stages have analog gain errors and deliberate overlap, so the raw bits are not plain powers of two. The unit therefore gives each raw bit its own programmable weight. It adds the weights of the bits that are set, rounds the sum to a 14-bit sample with saturation, and shifts that sample out on a per-channel serial line. A one-cycle frame marker goes with the first bit.

The unit serves `NUM_CH` channels in parallel. All channels share one sample strobe, one frame marker and one weight-write port. Each channel has its own weight set, accumulator and shifter. A sample arrives with the strobe every sample period (25 ns at a 40 MHz sample rate, which is 16 cycles of a 640 MHz core clock). A calibration agent can rewrite any weight at any time. A weight write never disturbs a sample that is already in flight.

Top module: `adc_corr_unit`

## Requirements
- R1: During and after reset, `frm_o` and every `ser_out` bit are 0. Each weight starts at its nominal value: fine bit i weighs 2^i and coarse bit j weighs 2^(11+j), in output units.
- R2: A weight is an 18-bit unsigned number with 4 fractional bits. Raw index 0..11 is fine-code bit 0..11 (`sar_code[c*12+i]`). Raw index 12..14 is coarse-code bit 0..2 (`mdac_code[c*3+j]`). The channel result is the sum of the weights of the raw bits that are 1.
- R3: The sum is divided by 16 and rounded to the nearest integer, and an exact half rounds up.
- R4: A rounded value above 16383 is sent as 16383.
- R5: A frame sends the 14-bit result MSB first over 14 consecutive cycles, one bit per cycle. `frm_o` is high only in the MSB cycle. After the LSB, `ser_out` stays 0 until the next frame.
- R6: A strobe in cycle n gives `frm_o` high and the MSB on `ser_out` in cycle n+2 (a latency of 2 cycles).
- R7: A weight write to address {channel, raw index} is applied at the next clock edge. It affects samples whose strobe comes in a later cycle. A write in the same cycle as the strobe, or in any later cycle, leaves that sample unchanged.
- R8: A write with raw index 15 changes no weight.
- R9: A write to channel c changes only the weights of channel c.
- R10: A strobe that arrives while a frame is still being sent drops that frame. The new sample's frame starts two cycles after the new strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, several times the sample rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | One-cycle sample strobe; codes are valid in this cycle |
| mdac_code | input | NUM_CH*3 | Coarse codes, 3 bits per channel, channel 0 in the low bits |
| sar_code | input | NUM_CH*12 | Fine codes, 12 bits per channel, channel 0 in the low bits |
| wr_en | input | 1 | Weight write enable |
| wr_addr | input | CH_AW+4 | {channel, raw index}; raw index in bits 3:0 |
| wr_data | input | 18 | Weight value, unsigned, 4 fractional bits |
| ser_out | output | NUM_CH | Serial corrected sample, one line per channel |
| frm_o | output | 1 | Marks the MSB cycle of every channel's frame |

## Verification
A weight write and a sample capture can land in the same cycle. So can a new strobe and a frame that is still shifting out. The bench places a write exactly on the strobe cycle and another one in the cycle between capture and shifter load. In both cases it expects the frame to use the old weight and the next sample to use the new one. It also issues a second strobe five cycles into a frame and expects the second sample's bits to start two cycles after that strobe, with no remnant of the dropped frame.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;

  localparam int MDAC_W = 3;
  localparam int SAR_W  = 12;
  localparam int RAW_W  = MDAC_W + SAR_W;
  localparam int WGT_W  = 18;
  localparam int FRAC_W = 4;
  localparam int OUT_W  = 14;
  localparam int SUM_W  = WGT_W + $clog2(RAW_W);
  localparam int IDX_W  = $clog2(RAW_W + 1);
  localparam int HALF   = 1 << (FRAC_W - 1);
  localparam int LATENCY = 2;

  // nominal weight: fine bit i -> 2^i, coarse bit j (raw index 12+j) -> 2^(11+j)
  function automatic logic [WGT_W-1:0] nominal_weight(input int idx);
    int p;
    p = (idx < SAR_W) ? idx : idx - 1;
    return WGT_W'(1) << (p + FRAC_W);
  endfunction

  function automatic logic [SUM_W-1:0] weighted_sum(
    input logic [RAW_W-1:0]       raw,
    input logic [RAW_W*WGT_W-1:0] wts
  );
    logic [SUM_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < RAW_W; i++) begin
      if (raw[i]) acc = acc + SUM_W'(wts[i*WGT_W +: WGT_W]);
    end
    return acc;
  endfunction

  function automatic logic [OUT_W-1:0] round_sat(input logic [SUM_W-1:0] s);
    logic [SUM_W:0]        r;
    logic [SUM_W-FRAC_W:0] q;
    r = {1'b0, s} + (SUM_W+1)'(HALF);
    q = r[SUM_W:FRAC_W];
    if (|q[SUM_W-FRAC_W:OUT_W]) return '1;
    return q[OUT_W-1:0];
  endfunction

endpackage

// File: rtl/adc_corr_wbank.sv
module adc_corr_wbank
  import adc_corr_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_AW  = 3
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [CH_AW-1:0]                  wr_ch,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [WGT_W-1:0]                  wr_data,
  output logic [NUM_CH*RAW_W*WGT_W-1:0]     wts
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    for (genvar i = 0; i < RAW_W; i++) begin : g_bit
      logic hit;
      assign hit = wr_en && (wr_ch == CH_AW'(c)) && (wr_idx == IDX_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   wts[(c*RAW_W+i)*WGT_W +: WGT_W] <= nominal_weight(i);
        else if (hit) wts[(c*RAW_W+i)*WGT_W +: WGT_W] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/adc_corr_frame.sv
module adc_corr_frame
  import adc_corr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic smp_stb,
  output logic load,
  output logic frm,
  output logic live
);

  localparam int CNT_W = $clog2(OUT_W + 1);

  logic [CNT_W-1:0] bits_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load      <= 1'b0;
      frm       <= 1'b0;
      bits_left <= '0;
    end else begin
      load <= smp_stb;
      frm  <= load;
      if (load)                 bits_left <= CNT_W'(OUT_W);
      else if (bits_left != '0) bits_left <= bits_left - CNT_W'(1);
    end
  end

  assign live = (bits_left != '0);

endmodule

// File: rtl/adc_corr_lane.sv
module adc_corr_lane
  import adc_corr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cap,
  input  logic                       load,
  input  logic [RAW_W-1:0]           raw,
  input  logic [RAW_W*WGT_W-1:0]     wts,
  output logic [SUM_W-1:0]           sum_q,
  output logic [OUT_W-1:0]           shreg,
  output logic                       ser
);

  // stage 1: sum captured on the strobe edge with the weights in force then
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sum_q <= '0;
    else if (cap) sum_q <= weighted_sum(raw, wts);
  end

  // stage 2: rounded/saturated load, then MSB-first shift with zero fill
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    shreg <= '0;
    else if (load) shreg <= round_sat(sum_q);
    else           shreg <= {shreg[OUT_W-2:0], 1'b0};
  end

  assign ser = shreg[OUT_W-1];

endmodule

// File: rtl/adc_corr_unit.sv
module adc_corr_unit
  import adc_corr_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_AW  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     smp_stb,
  input  logic [NUM_CH*MDAC_W-1:0] mdac_code,
  input  logic [NUM_CH*SAR_W-1:0]  sar_code,
  input  logic                     wr_en,
  input  logic [CH_AW+IDX_W-1:0]   wr_addr,
  input  logic [WGT_W-1:0]         wr_data,
  output logic [NUM_CH-1:0]        ser_out,
  output logic                     frm_o
);

  logic [NUM_CH*RAW_W*WGT_W-1:0] wts;
  logic [SUM_W-1:0]              lane_sum [NUM_CH];
  logic [OUT_W-1:0]              lane_sh  [NUM_CH];

  // named internal events for the checker
  logic                   probe_load;
  logic                   probe_live;
  logic [SUM_W-1:0]       probe_sum0;
  logic [OUT_W-1:0]       probe_sh0;
  logic [RAW_W*WGT_W-1:0] probe_w0;

  adc_corr_wbank #(.NUM_CH(NUM_CH), .CH_AW(CH_AW)) u_wbank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_ch   (wr_addr[IDX_W +: CH_AW]),
    .wr_idx  (wr_addr[IDX_W-1:0]),
    .wr_data (wr_data),
    .wts     (wts)
  );

  adc_corr_frame u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_stb (smp_stb),
    .load    (probe_load),
    .frm     (frm_o),
    .live    (probe_live)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    adc_corr_lane u_lane (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (smp_stb),
      .load  (probe_load),
      .raw   ({mdac_code[c*MDAC_W +: MDAC_W], sar_code[c*SAR_W +: SAR_W]}),
      .wts   (wts[c*RAW_W*WGT_W +: RAW_W*WGT_W]),
      .sum_q (lane_sum[c]),
      .shreg (lane_sh[c]),
      .ser   (ser_out[c])
    );
  end

  assign probe_sum0 = lane_sum[0];
  assign probe_sh0  = lane_sh[0];
  assign probe_w0   = wts[RAW_W*WGT_W-1:0];

endmodule

// File: rtl/adc_corr_unit_chk.sv
module adc_corr_unit_chk
  import adc_corr_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   smp_stb,
  input logic                   wr_en,
  input logic                   frm_o,
  input logic [NUM_CH-1:0]      ser_out,
  input logic                   probe_load,
  input logic                   probe_live,
  input logic [SUM_W-1:0]       probe_sum0,
  input logic [OUT_W-1:0]       probe_sh0,
  input logic [RAW_W*WGT_W-1:0] probe_w0
);

  localparam logic [SUM_W-1:0] SAT_LIM =
    SUM_W'((2**OUT_W - 1) * (2**FRAC_W) + HALF);

  // R6: frame marker two cycles after every strobe
  a_r6_latency: assert property (@(posedge clk) disable iff (!rst_n)
    smp_stb |=> ##1 frm_o);

  // R6: no frame marker without a strobe two cycles before
  a_r6_origin: assert property (@(posedge clk) disable iff (!rst_n)
    frm_o |-> $past(smp_stb, 2));

  // R5: between loads the channel-0 shifter moves one place toward the MSB
  a_r5_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !probe_load |=> probe_sh0 == ($past(probe_sh0) << 1));

  // R5: outside a frame every serial line is low
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !probe_live |-> ser_out == '0);

  // R4: a sum at or past the limit loads all ones
  a_r4_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_load && probe_sum0 >= SAT_LIM) |=> probe_sh0 == '1);

  // R7: weights move only on a write
  a_r7_weight_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(probe_w0));

endmodule

bind adc_corr_unit adc_corr_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smp_stb    (smp_stb),
  .wr_en      (wr_en),
  .frm_o      (frm_o),
  .ser_out    (ser_out),
  .probe_load (probe_load),
  .probe_live (probe_live),
  .probe_sum0 (probe_sum0),
  .probe_sh0  (probe_sh0),
  .probe_w0   (probe_w0)
);

// File: tb/test_adc_corr_unit.sv
`timescale 1ns/1ps
module test_adc_corr_unit;

  localparam int NCH = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              smp_stb;
  logic [NCH*3-1:0]  mdac_code;
  logic [NCH*12-1:0] sar_code;
  logic              wr_en;
  logic [6:0]        wr_addr;
  logic [17:0]       wr_data;
  logic [NCH-1:0]    ser_out;
  logic              frm_o;

  always #2.5 clk = ~clk;

  adc_corr_unit #(.NUM_CH(NCH)) i_adc_corr_unit (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
    .mdac_code(mdac_code), .sar_code(sar_code),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ser_out(ser_out), .frm_o(frm_o)
  );

  int          n_chk = 0;
  int          n_fail = 0;
  int unsigned mw [NCH][15];
  int unsigned rng = 32'h1234_5678;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int unsigned next_rng();
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    return rng;
  endfunction

  function automatic int unsigned model_out(input int c);
    longint unsigned acc, q;
    logic [2:0]  m;
    logic [11:0] s;
    bit b;
    m = mdac_code[c*3 +: 3];
    s = sar_code[c*12 +: 12];
    acc = 0;
    for (int k = 0; k < 15; k++) begin
      b = (k < 12) ? s[k] : m[k-12];
      if (b) acc += mw[c][k];
    end
    q = acc / 16;
    if ((acc % 16) >= 8) q++;
    if (q > 16383) q = 16383;
    return int'(q);
  endfunction

  function automatic void model_write(input int ch, input int idx, input int unsigned d);
    if (idx < 15 && ch < NCH) mw[ch][idx] = d;
  endfunction

  task automatic write_w(input int ch, input int idx, input int unsigned d);
    wr_en = 1'b1; wr_addr = {3'(ch), 4'(idx)}; wr_data = 18'(d);
    @(negedge clk);
    wr_en = 1'b0;
    model_write(ch, idx, d);
  endtask

  // called just after a negedge with codes already set; wr_mode 0 none,
  // 1 write in the strobe cycle, 2 write in the cycle after the strobe
  task automatic sample_frame(input string req, input int wr_mode,
                              input int wch, input int widx, input int unsigned wd);
    int unsigned exp_v [NCH];
    logic [13:0] got   [NCH];
    for (int c = 0; c < NCH; c++) exp_v[c] = model_out(c);
    smp_stb = 1'b1;
    if (wr_mode == 1) begin
      wr_en = 1'b1; wr_addr = {3'(wch), 4'(widx)}; wr_data = 18'(wd);
    end
    @(negedge clk);
    smp_stb = 1'b0; wr_en = 1'b0;
    if (wr_mode == 1) model_write(wch, widx, wd);
    chk(frm_o == 1'b0, "R6 marker one cycle after strobe", frm_o, 0);
    if (wr_mode == 2) begin
      wr_en = 1'b1; wr_addr = {3'(wch), 4'(widx)}; wr_data = 18'(wd);
    end
    @(negedge clk);
    wr_en = 1'b0;
    if (wr_mode == 2) model_write(wch, widx, wd);
    for (int k = 0; k < 14; k++) begin
      if (k > 0) @(negedge clk);
      if (k == 0) chk(frm_o == 1'b1, "R6 marker two cycles after strobe", frm_o, 1);
      if (k == 1) chk(frm_o == 1'b0, "R5 marker single cycle", frm_o, 0);
      for (int c = 0; c < NCH; c++) got[c][13-k] = ser_out[c];
    end
    for (int c = 0; c < NCH; c++)
      chk(got[c] == 14'(exp_v[c]), req, got[c], exp_v[c]);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R5 watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0; smp_stb = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    mdac_code = '0; sar_code = '0;
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 15; k++)
        mw[c][k] = (k < 12) ? (32'd1 << (k + 4)) : (32'd1 << (k - 1 + 4));
    repeat (3) @(negedge clk);
    chk(frm_o == 1'b0 && ser_out == '0, "R1 outputs in reset", {frm_o, ser_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(frm_o == 1'b0 && ser_out == '0, "R1 outputs after reset", {frm_o, ser_out}, 0);

    // R1 R2: every 15-bit raw code under nominal weights, 8 codes per sample
    for (int n = 0; n < 4096; n++) begin
      for (int c = 0; c < NCH; c++) begin
        logic [14:0] v;
        v = 15'(n * NCH + c);
        mdac_code[c*3 +: 3]   = v[14:12];
        sar_code[c*12 +: 12]  = v[11:0];
      end
      sample_frame("R1 R2 nominal sweep", 0, 0, 0, 0);
    end
    @(negedge clk);
    chk(ser_out == '0 && frm_o == 1'b0, "R5 idle after frame", ser_out, 0);

    // R2 R9: programmed near-nominal weights, per channel
    for (int c = 0; c < NCH; c++)
      for (int k = 0; k < 15; k++)
        write_w(c, k, ((k < 12) ? (32'd1 << (k + 4)) : (32'd1 << (k + 3)))
                      + (next_rng() % 16) - 8);
    for (int n = 0; n < 512; n++) begin
      mdac_code = NCH*3'(next_rng());
      sar_code  = {next_rng(), next_rng(), next_rng()};
      sample_frame("R2 R9 programmed weights", 0, 0, 0, 0);
    end

    // R3: rounding on channel 0 (0.5 -> 1, 0.4375 -> 0, 1.5 -> 2)
    write_w(0, 0, 8); write_w(0, 1, 7); write_w(0, 2, 24);
    mdac_code = '0; sar_code = '0;
    for (int s = 1; s < 8; s++) begin
      sar_code[11:0] = 12'(s);
      sample_frame("R3 round half up", 0, 0, 0, 0);
    end

    // R4: saturation on channels 1 and 2
    for (int k = 0; k < 15; k++) write_w(1, k, 32'h3FFFF);
    write_w(2, 0, 16382*16 + 8);
    write_w(2, 1, 16383*16 + 8);
    mdac_code = '0; sar_code = '0;
    mdac_code[5:3] = 3'b111; sar_code[23:12] = 12'hFFF; sar_code[24] = 1'b1;
    sample_frame("R4 saturate and exact max", 0, 0, 0, 0);
    sar_code[35:24] = 12'h002;
    sample_frame("R4 half above max", 0, 0, 0, 0);

    // R7: write on the strobe cycle and in the following cycle
    mdac_code = '0; sar_code = '0; sar_code[36] = 1'b1;
    sample_frame("R7 write on strobe keeps old weight", 1, 3, 0, 1000);
    sample_frame("R7 new weight at next sample", 2, 3, 0, 2000);
    sample_frame("R7 write after capture applied next", 0, 0, 0, 0);

    // R8: raw index 15 writes nothing; R9 write elsewhere leaves others
    write_w(4, 15, 32'h3FFFF);
    write_w(5, 3, 5000);
    mdac_code = '1; sar_code = '1;
    sample_frame("R8 R9 ignored index and isolation", 0, 0, 0, 0);

    // R10: second strobe five cycles into a frame restarts it
    begin
      int unsigned exp_b [NCH];
      logic [13:0] got_b [NCH];
      mdac_code = '0; sar_code = '1;
      smp_stb = 1'b1;
      @(negedge clk); smp_stb = 1'b0;
      repeat (4) @(negedge clk);
      mdac_code = '0; sar_code = '0;
      for (int c = 0; c < NCH; c++) begin
        sar_code[c*12 +: 12] = 12'(37 * c + 5);
        exp_b[c] = model_out(c);
      end
      smp_stb = 1'b1;
      @(negedge clk); smp_stb = 1'b0;
      @(negedge clk);
      for (int k = 0; k < 14; k++) begin
        if (k > 0) @(negedge clk);
        if (k == 0) chk(frm_o == 1'b1, "R10 restart marker", frm_o, 1);
        for (int c = 0; c < NCH; c++) got_b[c][13-k] = ser_out[c];
      end
      for (int c = 0; c < NCH; c++)
        chk(got_b[c] == 14'(exp_b[c]), "R10 restarted frame", got_b[c], exp_b[c]);
      @(negedge clk);
      chk(ser_out == '0, "R10 R5 no remnant after restart", ser_out, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule